// File: doc/BRIEF.md
# Adaptive Prefetch Slip Control Queue

This block is a token queue that limits how far a prefetching engine may run ahead of the engine that issues the matching loads. After the prefetch engine has issued the prefetches for one loop iteration, it pushes a token. Before the load engine issues the loads for one iteration, it pops a token. A push stalls while the number of outstanding tokens has reached a depth limit. A pop stalls while no token is outstanding.

The depth limit changes at run time. Each prefetch is reported once, and the report says whether the prefetch was late or useful. A late prefetch is one whose data returned after its load had already been issued. A useful prefetch is one whose data returned in time. The block counts both kinds of report. After a programmable number of reports it evaluates the counts and then clears them.

The outcome of an evaluation depends on the prefetch buffer, which has eight entries and reports a full flag. If that buffer is full, the limit stays as it is. Otherwise, if twice the late count exceeds the useful count, the limit grows by one. In every other case the limit shrinks by one. The limit always stays between 1 and 128.

Top module: `slip_ctl_queue`

## Requirements
- R1: In reset, occupancy becomes 0 and the depth limit becomes `cfg_init_limit` clamped to the range 1..128. A value of 0 gives 1, and a value above 128 gives 128.
- R2: A push is accepted when `put_req` is high and occupancy is below the depth limit. On acceptance, occupancy rises by one at the next clock edge. When a push is refused, `put_stall` is high in the same cycle.
- R3: A pop is accepted when `get_req` is high and occupancy is nonzero. On acceptance, occupancy falls by one at the next edge. When occupancy is zero, `get_stall` is high while `get_req` is high, and occupancy stays 0.
- R4: When a push and a pop are both accepted in the same cycle, occupancy is unchanged.
- R5: Each cycle in which `pf_valid` is high reports one prefetch: `pf_late`=1 means late and `pf_late`=0 means useful. The report that brings the count of reports to `cfg_window` triggers an evaluation, and a window of 0 acts as 1. The new limit is visible after the clock edge that ends the triggering cycle. Both counts then restart from zero, and between evaluations the limit does not change.
- R6: If `pbuf_full` is high in the triggering cycle, the depth limit is held.
- R7: If `pbuf_full` is low and 2*late > useful, the depth limit increases by one.
- R8: If `pbuf_full` is low and 2*late <= useful, which includes the case where the two are equal, the depth limit decreases by one.
- R9: The depth limit never goes below 1 or above 128. An increase at 128 and a decrease at 1 leave the limit unchanged.
- R10: When the limit drops below the occupancy, no token is lost. Pushes stall until occupancy has fallen below the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_init_limit | input | 8 | Depth limit loaded in reset |
| cfg_window | input | 8 | Number of reports per evaluation |
| put_req | input | 1 | Prefetch side pushes a token |
| get_req | input | 1 | Load side pops a token |
| pf_valid | input | 1 | One prefetch outcome is reported this cycle |
| pf_late | input | 1 | 1 = late outcome, 0 = useful outcome |
| pbuf_full | input | 1 | Prefetch buffer full flag |
| put_stall | output | 1 | Push refused this cycle |
| get_stall | output | 1 | Pop refused this cycle |
| occupancy | output | 8 | Outstanding tokens |
| depth_limit | output | 8 | Current depth limit |

## Verification
The stall outputs are combinational, so they are checked in the same cycle as the request, one time unit after the inputs change. Occupancy and the depth limit are registered, so they are checked one time unit after the clock edge that ends the cycle of the request or of the triggering report. To confirm that the limit does not move early, the bench also reads it just before the window-closing report. The bench runs the ratio tie, the full-buffer hold, both clamps and a limit that shrinks below occupancy as separate directed scenarios.

// File: rtl/scq_pkg.sv
package scq_pkg;
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_HOLD = 2'd1,
        ADJ_UP   = 2'd2,
        ADJ_DOWN = 2'd3
    } adj_e;
endpackage

// File: rtl/scq_token_ctr.sv
module scq_token_ctr #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             put_req,
    input  logic             get_req,
    input  logic [LIM_W-1:0] limit,
    output logic             put_stall,
    output logic             get_stall,
    output logic [LIM_W-1:0] occ
);
    typedef struct packed {
        logic [LIM_W-1:0] occ;
    } tok_st_t;

    tok_st_t s_q, s_d;
    logic put_ok, get_ok;

    always_comb begin
        put_ok    = put_req && (s_q.occ < limit);
        get_ok    = get_req && (s_q.occ != '0);
        put_stall = put_req && !put_ok;
        get_stall = get_req && !get_ok;
        s_d       = s_q;
        case ({put_ok, get_ok})
            2'b10:   s_d.occ = s_q.occ + LIM_W'(1);
            2'b01:   s_d.occ = s_q.occ - LIM_W'(1);
            default: s_d.occ = s_q.occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign occ = s_q.occ;

    AST_PUT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (put_req && !put_stall && !get_req) |=> occ == $past(occ) + LIM_W'(1)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (get_req && get_stall && !put_req) |=> $stable(occ)); // R3
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (put_req && get_req && !put_stall && !get_stall) |=> $stable(occ)); // R4
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (put_req && put_stall && !get_req) |=> $stable(occ)); // R10
endmodule

// File: rtl/scq_outcome_ctr.sv
module scq_outcome_ctr #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_valid,
    input  logic             pf_late,
    input  logic [WIN_W-1:0] cfg_window,
    output logic             eval,
    output logic [WIN_W-1:0] late_tot,
    output logic [WIN_W-1:0] useful_tot
);
    typedef struct packed {
        logic [WIN_W-1:0] late;
        logic [WIN_W-1:0] useful;
        logic [WIN_W-1:0] seen;
    } cnt_st_t;

    cnt_st_t s_q, s_d;
    logic [WIN_W-1:0] late_n, useful_n, seen_n;

    always_comb begin
        late_n     = s_q.late   + WIN_W'(pf_valid && pf_late);
        useful_n   = s_q.useful + WIN_W'(pf_valid && !pf_late);
        seen_n     = s_q.seen   + WIN_W'(pf_valid);
        eval       = pf_valid && (seen_n >= cfg_window);
        late_tot   = late_n;
        useful_tot = useful_n;
        if (eval) s_d = '0;
        else      s_d = '{late: late_n, useful: useful_n, seen: seen_n};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (s_q.seen == '0 && s_q.late == '0 && s_q.useful == '0)); // R5
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_valid |=> $stable(s_q.seen)); // R5
endmodule

// File: rtl/scq_limit_ctl.sv
module scq_limit_ctl
    import scq_pkg::*;
#(
    parameter int LIM_MIN = 1,
    parameter int LIM_MAX = 128,
    parameter int LIM_W   = 8,
    parameter int WIN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] cfg_init_limit,
    input  logic             eval,
    input  logic             pbuf_full,
    input  logic [WIN_W-1:0] late_tot,
    input  logic [WIN_W-1:0] useful_tot,
    output logic [LIM_W-1:0] limit
);
    localparam logic [LIM_W-1:0] MIN_V = LIM_W'(LIM_MIN);
    localparam logic [LIM_W-1:0] MAX_V = LIM_W'(LIM_MAX);

    typedef struct packed {
        logic [LIM_W-1:0] limit;
    } lim_st_t;

    lim_st_t s_q, s_d;
    adj_e    adj;
    logic [LIM_W-1:0] init_clamped;

    always_comb begin
        if (cfg_init_limit < MIN_V)      init_clamped = MIN_V;
        else if (cfg_init_limit > MAX_V) init_clamped = MAX_V;
        else                             init_clamped = cfg_init_limit;

        if (!eval)                                   adj = ADJ_NONE;
        else if (pbuf_full)                          adj = ADJ_HOLD;
        else if ({late_tot, 1'b0} > {1'b0, useful_tot}) adj = ADJ_UP;
        else                                         adj = ADJ_DOWN;

        s_d = s_q;
        case (adj)
            ADJ_UP:   if (s_q.limit < MAX_V) s_d.limit = s_q.limit + LIM_W'(1);
            ADJ_DOWN: if (s_q.limit > MIN_V) s_d.limit = s_q.limit - LIM_W'(1);
            default:  s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.limit <= init_clamped;
        else        s_q       <= s_d;
    end

    assign limit = s_q.limit;

    AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (limit >= MIN_V && limit <= MAX_V)); // R9
    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && pbuf_full) |=> $stable(limit)); // R6
    AST_NO_EVAL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(limit)); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (limit == $past(limit) || limit == $past(limit) + LIM_W'(1)
                  || limit == $past(limit) - LIM_W'(1))); // R7
endmodule

// File: rtl/slip_ctl_queue.sv
module slip_ctl_queue #(
    parameter int LIM_MIN = 1,
    parameter int LIM_MAX = 128,
    parameter int WIN_W   = 8,
    localparam int LIM_W  = $clog2(LIM_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] cfg_init_limit,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic             put_req,
    input  logic             get_req,
    input  logic             pf_valid,
    input  logic             pf_late,
    input  logic             pbuf_full,
    output logic             put_stall,
    output logic             get_stall,
    output logic [LIM_W-1:0] occupancy,
    output logic [LIM_W-1:0] depth_limit
);
    logic             eval;
    logic [WIN_W-1:0] late_tot, useful_tot;

    scq_token_ctr #(.LIM_W(LIM_W)) u_tok (
        .clk(clk), .rst_n(rst_n), .put_req(put_req), .get_req(get_req),
        .limit(depth_limit), .put_stall(put_stall), .get_stall(get_stall),
        .occ(occupancy)
    );

    scq_outcome_ctr #(.WIN_W(WIN_W)) u_out (
        .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_late(pf_late),
        .cfg_window(cfg_window), .eval(eval), .late_tot(late_tot),
        .useful_tot(useful_tot)
    );

    scq_limit_ctl #(.LIM_MIN(LIM_MIN), .LIM_MAX(LIM_MAX), .LIM_W(LIM_W), .WIN_W(WIN_W)) u_lim (
        .clk(clk), .rst_n(rst_n), .cfg_init_limit(cfg_init_limit), .eval(eval),
        .pbuf_full(pbuf_full), .late_tot(late_tot), .useful_tot(useful_tot),
        .limit(depth_limit)
    );

    AST_GET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0 && !put_req) |=> occupancy == '0); // R3
endmodule

// File: tb/sim_slip_ctl_queue.sv
module sim_slip_ctl_queue;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_init_limit = 8'd4;
    logic [7:0] cfg_window = 8'd4;
    logic       put_req = 1'b0, get_req = 1'b0;
    logic       pf_valid = 1'b0, pf_late = 1'b0, pbuf_full = 1'b0;
    logic       put_stall, get_stall;
    logic [7:0] occupancy, depth_limit;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slip_ctl_queue u0 (
        .clk(clk), .rst_n(rst_n), .cfg_init_limit(cfg_init_limit),
        .cfg_window(cfg_window), .put_req(put_req), .get_req(get_req),
        .pf_valid(pf_valid), .pf_late(pf_late), .pbuf_full(pbuf_full),
        .put_stall(put_stall), .get_stall(get_stall),
        .occupancy(occupancy), .depth_limit(depth_limit)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int init, input int win);
        rst_n = 1'b0;
        cfg_init_limit = 8'(init);
        cfg_window = 8'(win);
        put_req = 0; get_req = 0; pf_valid = 0; pf_late = 0; pbuf_full = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
    endtask

    task automatic feed(input bit late, input int n, input bit full);
        for (int i = 0; i < n; i++) begin
            pf_valid = 1'b1; pf_late = late; pbuf_full = full;
            tick();
        end
        pf_valid = 1'b0; pbuf_full = 1'b0;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            put_req = 1'b1;
            tick();
        end
        put_req = 1'b0;
    endtask

    task automatic pop_n(input int n);
        for (int i = 0; i < n; i++) begin
            get_req = 1'b1;
            tick();
        end
        get_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(0, 4);
        chk("R1", "limit from init 0", depth_limit, 1);
        do_reset(200, 4);
        chk("R1", "limit from init 200", depth_limit, 128);
        do_reset(4, 4);
        chk("R1", "occupancy", occupancy, 0);
        chk("R1", "limit from init 4", depth_limit, 4);
        get_req = 1'b1; #1;
        chk("R3", "get_stall when empty", get_stall, 1);
        tick();
        chk("R3", "occupancy after refused pop", occupancy, 0);
        get_req = 1'b0;
    endtask

    task automatic t_fill();
        for (int i = 0; i < 5; i++) begin
            put_req = 1'b1; #1;
            chk("R2", "put_stall while filling", put_stall, (i >= 4) ? 1 : 0);
            tick();
            chk("R2", "occupancy while filling", occupancy, (i + 1 > 4) ? 4 : i + 1);
        end
        put_req = 1'b0;
    endtask

    task automatic t_mix();
        put_req = 1'b1; get_req = 1'b1; #1;
        chk("R2", "put_stall at limit with pop", put_stall, 1);
        chk("R3", "get_stall at limit", get_stall, 0);
        tick();
        chk("R3", "occupancy after pop only", occupancy, 3);
        #1;
        chk("R4", "put_stall both legal", put_stall, 0);
        chk("R4", "get_stall both legal", get_stall, 0);
        tick();
        chk("R4", "occupancy both legal", occupancy, 3);
        put_req = 1'b0; get_req = 1'b0;
        pop_n(3);
        chk("R3", "occupancy drained", occupancy, 0);
        put_req = 1'b1; get_req = 1'b1; #1;
        chk("R3", "get_stall empty with push", get_stall, 1);
        tick();
        chk("R2", "occupancy push with refused pop", occupancy, 1);
        put_req = 1'b0; get_req = 1'b0;
        pop_n(1);
    endtask

    task automatic t_adjust();
        feed(1, 2, 0);
        feed(0, 1, 0);
        chk("R5", "limit before window closes", depth_limit, 4);
        feed(0, 1, 0);
        chk("R7", "limit after 2 late 2 useful", depth_limit, 5);
        feed(1, 1, 0);
        feed(0, 3, 0);
        chk("R8", "limit after 1 late 3 useful", depth_limit, 4);
        cfg_window = 8'd3;
        feed(1, 1, 0);
        feed(0, 2, 0);
        chk("R8", "limit on tie 2*1 == 2", depth_limit, 3);
        cfg_window = 8'd4;
    endtask

    task automatic t_hold();
        feed(1, 3, 0);
        feed(1, 1, 1);
        chk("R6", "limit held with buffer full", depth_limit, 3);
        feed(0, 4, 0);
        chk("R5", "counts cleared after window", depth_limit, 2);
    endtask

    task automatic t_clamp();
        cfg_window = 8'd1;
        feed(0, 4, 0);
        chk("R9", "limit floor", depth_limit, 1);
        feed(1, 130, 0);
        chk("R9", "limit ceiling", depth_limit, 128);
    endtask

    task automatic t_shrink();
        do_reset(4, 1);
        push_n(4);
        feed(0, 2, 0);
        chk("R10", "limit shrunk", depth_limit, 2);
        chk("R10", "tokens kept", occupancy, 4);
        put_req = 1'b1; #1;
        chk("R10", "put_stall above limit", put_stall, 1);
        tick();
        put_req = 1'b0;
        chk("R10", "occupancy unchanged", occupancy, 4);
        pop_n(2);
        put_req = 1'b1; #1;
        chk("R10", "put_stall at limit", put_stall, 1);
        put_req = 1'b0;
        pop_n(1);
        put_req = 1'b1; #1;
        chk("R10", "put accepted below limit", put_stall, 0);
        tick();
        put_req = 1'b0;
        chk("R10", "occupancy after accepted push", occupancy, 2);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_mix();
        t_adjust();
        t_hold();
        t_clamp();
        t_shrink();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule